// File: doc/BRIEF.md
# Programmable Parallel-Bus Strobe Timing Generator

This block runs one access at a time on an asynchronous, 8080-style parallel display bus. The bus has a chip select, a write strobe, a read strobe and a line that marks each access as a command or as data. Each access is a cycle counted in ticks. A tick is one input clock, or two input clocks when the slow-tick option is set. Within the cycle, every strobe turns on and off at a programmed tick. The requester offers command writes, data writes and reads through a valid/ready handshake. Read data is captured from the bus at the programmed access tick and is returned with a one-clock valid pulse.

Two packed configuration words set the edge times. Before use, a combinational legaliser clamps them so that every off edge comes after its on edge and the chip select covers both strobes. Each cycle length is also stretched to cover the chip-select release and, for reads, the access point. The clamped set is captured when an access is accepted. The strobe levels come from the current polarity bits.

Top module: `pbus_strobe_gen`

## Requirements
- R1: The edge word holds the select-on tick in bits 3:0, select-off in 9:4, write-on in 13:10, write-off in 19:14, read-on in 23:20 and read-off in 29:24. A strobe is active in ticks t with on <= t < off. Tick 0 is the first tick after the accepting clock edge.
- R2: The cycle word holds the write cycle in bits 5:0, the read cycle in 11:6 and the access tick in 27:22. Bits 21:12 have no effect.
- R3: Before use, write-off is raised to at least write-on+1 and read-off to at least read-on+1. Select-off is raised to at least select-on+1 and to at least the larger of the two strobe-off values. The access tick is raised to at least read-on+1.
- R4: A write lasts max(write cycle, write-off, select-off) ticks. A read lasts max(read cycle, read-off, select-off, access tick) ticks.
- R5: With cfg_slow high, every tick lasts two input clocks. With cfg_slow low, every tick lasts one.
- R6: cfg_pol bit 3 sets the chip-select polarity, bit 2 the write strobe, bit 1 the read strobe and bit 0 the command/data line. With a 0 bit, the strobes are active low and the command state is low. A 1 bit inverts that line.
- R7: req_op 0 is a command write and drives the command state. Op 1 (and 3) is a data write and op 2 is a read; both drive the data state. While idle, the line rests in the data state.
- R8: A read samples bus_din at the clock edge that ends tick (access-1). It raises rsp_valid with that value for one clock, starting on the clock after the cycle's last clock.
- R9: After reset the block is idle: req_ready is high, all strobes are inactive and rsp_valid is low. During a cycle, req_ready is high only in the last clock of the last tick, so a request held pending starts the very next clock.
- R10: During a write cycle, bus_oe is high and bus_dout holds the accepted write data. During a read cycle, bus_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_edges | input | 30 | Packed strobe on/off ticks |
| cfg_cycle | input | 28 | Packed cycle lengths and access tick |
| cfg_slow | input | 1 | Tick of two clocks when high |
| cfg_pol | input | 4 | Polarity per line: select, write, read, command/data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high with valid |
| req_op | input | 2 | 0 command write, 1 data write, 2 read, 3 data write |
| req_wdata | input | DATA_W | Write value |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Captured read value |
| bus_cs | output | 1 | Chip select |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_dc | output | 1 | Command/data select |
| bus_oe | output | 1 | Data driver enable |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_din | input | DATA_W | Data sampled from the bus |

## Verification
A tick counter that is wrong by even one shows on the strobe lines at the first edge it governs. It also moves the point where req_ready rises, so the fault appears within the same access. The bench compares every clock of every cycle against the clamped timing. A faulty clamp or misplaced bit field therefore moves an edge at a known tick and is reported in that access. The bench drives the read bus with a value that changes every tick. A capture made one tick early or late thus returns a different word, and the scoreboard catches it when rsp_valid rises.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   localparam int ON_W        = 4;
   localparam int OFF_W       = 6;
   localparam int EDGE_WORD_W = 30;
   localparam int CYC_WORD_W  = 28;

   // field positions within the edge word
   localparam int CSON_LSB  = 0;
   localparam int CSOFF_LSB = CSON_LSB + ON_W;
   localparam int WEON_LSB  = CSOFF_LSB + OFF_W;
   localparam int WEOFF_LSB = WEON_LSB + ON_W;
   localparam int REON_LSB  = WEOFF_LSB + OFF_W;
   localparam int REOFF_LSB = REON_LSB + ON_W;

   // field positions within the cycle word
   localparam int WCYC_LSB = 0;
   localparam int RCYC_LSB = WCYC_LSB + OFF_W;
   localparam int ACC_LSB  = 22;

   typedef logic [OFF_W-1:0] tick_t;
   localparam tick_t ONE_T = tick_t'(1);

   typedef enum logic [1:0] {
      OP_CMD  = 2'd0,
      OP_DATA = 2'd1,
      OP_READ = 2'd2,
      OP_ALT  = 2'd3
   } op_e;

   typedef struct packed {
      tick_t cs_on;
      tick_t cs_off;
      tick_t we_on;
      tick_t we_off;
      tick_t re_on;
      tick_t re_off;
      tick_t acc;
      tick_t wr_len;
      tick_t rd_len;
   } timing_t;

   function automatic tick_t tmax(input tick_t a, input tick_t b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pbus_timing_legal.sv
module pbus_timing_legal
   import pbus_pkg::*;
(
   input  logic [EDGE_WORD_W-1:0] edge_word,
   input  logic [CYC_WORD_W-1:0]  cyc_word,
   output timing_t                tim
);

   tick_t cs_on, we_on, re_on;
   tick_t we_off, re_off, cs_off;
   tick_t wcyc, rcyc, acc;

   always_comb begin
      cs_on  = tick_t'(edge_word[CSON_LSB +: ON_W]);
      we_on  = tick_t'(edge_word[WEON_LSB +: ON_W]);
      re_on  = tick_t'(edge_word[REON_LSB +: ON_W]);

      // each strobe must release strictly after it asserts
      we_off = tmax(edge_word[WEOFF_LSB +: OFF_W], we_on + ONE_T);
      re_off = tmax(edge_word[REOFF_LSB +: OFF_W], re_on + ONE_T);

      // chip select must outlast both strobes
      cs_off = tmax(tmax(edge_word[CSOFF_LSB +: OFF_W], cs_on + ONE_T),
                    tmax(we_off, re_off));

      wcyc   = tmax(cyc_word[WCYC_LSB +: OFF_W], we_off);
      rcyc   = tmax(cyc_word[RCYC_LSB +: OFF_W], re_off);
      acc    = tmax(cyc_word[ACC_LSB +: OFF_W], re_on + ONE_T);

      tim.cs_on  = cs_on;
      tim.cs_off = cs_off;
      tim.we_on  = we_on;
      tim.we_off = we_off;
      tim.re_on  = re_on;
      tim.re_off = re_off;
      tim.acc    = acc;
      tim.wr_len = tmax(wcyc, cs_off);
      tim.rd_len = tmax(tmax(rcyc, cs_off), acc);
   end

   logic unused_cyc_bits;
   assign unused_cyc_bits = ^cyc_word[ACC_LSB-1:RCYC_LSB+OFF_W];

endmodule

// File: rtl/pbus_tick_div.sv
module pbus_tick_div #(
   parameter bit SLOW_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow,
   input  logic restart,
   output logic tick
);

   generate
      if (SLOW_EN) begin : g_div
         logic ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ph <= 1'b0;
            else if (restart) ph <= 1'b0;
            else              ph <= ~ph;
         end
         assign tick = slow ? ph : 1'b1;
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^{clk, rst_n, slow, restart};
         assign tick = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pbus_edge_seq.sv
module pbus_edge_seq
   import pbus_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  timing_t           tim_in,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              accept,
   input  logic [DATA_W-1:0] bus_din,
   output logic              cs_act,
   output logic              we_act,
   output logic              re_act,
   output logic              dc_data,
   output logic              oe,
   output logic [DATA_W-1:0] dout,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic              busy;
   tick_t             tcnt;
   timing_t           tim_q;
   logic              rd_q;
   logic              cmd_q;
   logic [DATA_W-1:0] wdata_q;
   tick_t             len_cur;
   logic              last_tick;

   function automatic logic in_win(input tick_t t, input tick_t on, input tick_t off);
      return (t >= on) && (t < off);
   endfunction

   assign len_cur   = rd_q ? tim_q.rd_len : tim_q.wr_len;
   assign last_tick = busy && tick && (tcnt == len_cur - ONE_T);
   assign req_ready = !busy || last_tick;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         tcnt    <= '0;
         tim_q   <= '0;
         rd_q    <= 1'b0;
         cmd_q   <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         tcnt    <= '0;
         tim_q   <= tim_in;
         rd_q    <= (req_op == OP_READ);
         cmd_q   <= (req_op == OP_CMD);
         wdata_q <= req_wdata;
      end else if (last_tick) begin
         busy    <= 1'b0;
      end else if (busy && tick) begin
         tcnt    <= tcnt + ONE_T;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= last_tick && rd_q;
         if (busy && rd_q && tick && (tcnt == tim_q.acc - ONE_T))
            rsp_rdata <= bus_din;
      end
   end

   assign cs_act  = busy && in_win(tcnt, tim_q.cs_on, tim_q.cs_off);
   assign we_act  = busy && !rd_q && in_win(tcnt, tim_q.we_on, tim_q.we_off);
   assign re_act  = busy && rd_q && in_win(tcnt, tim_q.re_on, tim_q.re_off);
   assign dc_data = !(busy && cmd_q);
   assign oe      = busy && !rd_q;
   assign dout    = wdata_q;

endmodule

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
   import pbus_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit SLOW_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [EDGE_WORD_W-1:0] cfg_edges,
   input  logic [CYC_WORD_W-1:0]  cfg_cycle,
   input  logic                   cfg_slow,
   input  logic [3:0]             cfg_pol,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [1:0]             req_op,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   rsp_valid,
   output logic [DATA_W-1:0]      rsp_rdata,
   output logic                   bus_cs,
   output logic                   bus_we,
   output logic                   bus_re,
   output logic                   bus_dc,
   output logic                   bus_oe,
   output logic [DATA_W-1:0]      bus_dout,
   input  logic [DATA_W-1:0]      bus_din
);

   localparam int NUM_LINES = 4;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (ON_W >= OFF_W) begin : g_bad_fields
         $error("on-time fields must be narrower than off-time fields");
      end
      if (REOFF_LSB + OFF_W != EDGE_WORD_W) begin : g_bad_edge_word
         $error("edge word layout does not fill its width");
      end
   endgenerate

   timing_t tim;
   logic    tick;
   logic    accept;
   logic    cs_act, we_act, re_act, dc_data;
   logic [NUM_LINES-1:0] act_vec;
   logic [NUM_LINES-1:0] line_vec;

   pbus_timing_legal u_legal (
      .edge_word (cfg_edges),
      .cyc_word  (cfg_cycle),
      .tim       (tim)
   );

   pbus_tick_div #(.SLOW_EN(SLOW_EN)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .slow    (cfg_slow),
      .restart (accept),
      .tick    (tick)
   );

   pbus_edge_seq #(.DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .tim_in    (tim),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .accept    (accept),
      .bus_din   (bus_din),
      .cs_act    (cs_act),
      .we_act    (we_act),
      .re_act    (re_act),
      .dc_data   (dc_data),
      .oe        (bus_oe),
      .dout      (bus_dout),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   // line order: 3 select, 2 write, 1 read, 0 command/data
   assign act_vec = {cs_act, we_act, re_act, dc_data};

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_pol
         if (i == 0) begin : g_level
            assign line_vec[i] = act_vec[i] ^ cfg_pol[i];
         end else begin : g_strobe
            assign line_vec[i] = ~(act_vec[i] ^ cfg_pol[i]);
         end
      end
   endgenerate

   assign bus_cs = line_vec[3];
   assign bus_we = line_vec[2];
   assign bus_re = line_vec[1];
   assign bus_dc = line_vec[0];

endmodule

// File: rtl/pbus_strobe_gen_chk.sv
module pbus_strobe_gen_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        cfg_pol,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic              bus_we,
   input logic              bus_re,
   input logic              bus_oe,
   input logic [DATA_W-1:0] bus_dout,
   input logic              rsp_valid
);

   logic we_on, re_on, acc_hs;
   assign we_on  = (bus_we == cfg_pol[2]);
   assign re_on  = (bus_re == cfg_pol[1]);
   assign acc_hs = req_valid && req_ready;

   a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_on && re_on));

   a_r10_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !re_on);

   a_r10_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hs && (req_op != 2'd2)) |=> bus_oe);

   a_r10_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe) && !$past(acc_hs)) |-> $stable(bus_dout));

   a_r8_rsp_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_ready));

endmodule

bind pbus_strobe_gen pbus_strobe_gen_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_pol   (cfg_pol),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_oe    (bus_oe),
   .bus_dout  (bus_dout),
   .rsp_valid (rsp_valid)
);

// File: tb/pbus_strobe_gen_test.sv
module pbus_strobe_gen_test;

   localparam int DW = 16;
   localparam logic [DW-1:0] DIN_BASE = 16'hA500;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [29:0]   cfg_edges = '0;
   logic [27:0]   cfg_cycle = '0;
   logic          cfg_slow = 1'b0;
   logic [3:0]    cfg_pol = 4'h0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'd0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          bus_cs, bus_we, bus_re, bus_dc, bus_oe;
   logic [DW-1:0] bus_dout;
   logic [DW-1:0] bus_din = '0;

   always #10 clk = ~clk;

   pbus_strobe_gen #(.DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_edges(cfg_edges), .cfg_cycle(cfg_cycle),
      .cfg_slow(cfg_slow), .cfg_pol(cfg_pol), .req_valid(req_valid),
      .req_ready(req_ready), .req_op(req_op), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_cs(bus_cs),
      .bus_we(bus_we), .bus_re(bus_re), .bus_dc(bus_dc), .bus_oe(bus_oe),
      .bus_dout(bus_dout), .bus_din(bus_din)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [DW-1:0] exp_q[$];

   int l_cson, l_csoff, l_weon, l_weoff, l_reon, l_reoff, l_acc, l_wlen, l_rlen;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [29:0] mk_edges(input int cson, input int csoff, input int weon,
                                            input int weoff, input int reon, input int reoff);
      return {reoff[5:0], reon[3:0], weoff[5:0], weon[3:0], csoff[5:0], cson[3:0]};
   endfunction

   // bits 21:12 filled with ones to show they are ignored (R2)
   function automatic logic [27:0] mk_cycle(input int wcyc, input int rcyc, input int acc);
      return {acc[5:0], 4'hF, 6'h3F, rcyc[5:0], wcyc[5:0]};
   endfunction

   // clamp rules of R3 and cycle lengths of R4
   task automatic legalize();
      int wcyc, rcyc, acc;
      l_cson  = int'(cfg_edges[3:0]);
      l_csoff = int'(cfg_edges[9:4]);
      l_weon  = int'(cfg_edges[13:10]);
      l_weoff = int'(cfg_edges[19:14]);
      l_reon  = int'(cfg_edges[23:20]);
      l_reoff = int'(cfg_edges[29:24]);
      wcyc    = int'(cfg_cycle[5:0]);
      rcyc    = int'(cfg_cycle[11:6]);
      acc     = int'(cfg_cycle[27:22]);
      l_weoff = imax(l_weoff, l_weon + 1);
      l_reoff = imax(l_reoff, l_reon + 1);
      l_csoff = imax(imax(l_csoff, l_cson + 1), imax(l_weoff, l_reoff));
      l_acc   = imax(acc, l_reon + 1);
      l_wlen  = imax(imax(wcyc, l_weoff), l_csoff);
      l_rlen  = imax(imax(imax(rcyc, l_reoff), l_csoff), l_acc);
   endtask

   // checks every clock of an access that was accepted at the last edge
   task automatic body(input logic [1:0] op, input logic [DW-1:0] wd, input string req);
      bit rd, cmd, cs_a, we_a, re_a;
      int div, n, t;
      logic [5:0] e, a;
      legalize();
      rd  = (op == 2'd2);
      cmd = (op == 2'd0);
      div = cfg_slow ? 2 : 1;
      n   = (rd ? l_rlen : l_wlen) * div;
      if (rd) exp_q.push_back(DIN_BASE + DW'(l_acc - 1));
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k == 0) req_valid = 1'b0;
         t = k / div;
         bus_din = DIN_BASE + DW'(t);
         cs_a = (t >= l_cson) && (t < l_csoff);
         we_a = !rd && (t >= l_weon) && (t < l_weoff);
         re_a = rd && (t >= l_reon) && (t < l_reoff);
         e = {~(cs_a ^ cfg_pol[3]), ~(we_a ^ cfg_pol[2]), ~(re_a ^ cfg_pol[1]),
              (cmd ? 1'b0 : 1'b1) ^ cfg_pol[0], !rd, (k == n - 1)};
         a = {bus_cs, bus_we, bus_re, bus_dc, bus_oe, req_ready};
         check(a == e, req, $sformatf("lines cs/we/re/dc/oe/rdy tick %0d", t), 32'(a), 32'(e));
         if (!rd)
            check(bus_dout == wd, "R10", "bus_dout during write", 32'(bus_dout), 32'(wd));
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [DW-1:0] wd, input string req);
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      body(op, wd, req);
      repeat (3) @(negedge clk);
   endtask

   // first access is a write held pending with a second one behind it
   task automatic back_to_back(input logic [1:0] op1, input logic [DW-1:0] wd1,
                               input logic [1:0] op2, input logic [DW-1:0] wd2);
      int n1, waits;
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = op1;
      req_wdata = wd1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      legalize();
      n1 = l_wlen * (cfg_slow ? 2 : 1);
      waits = 0;
      @(negedge clk);
      req_op    = op2;
      req_wdata = wd2;
      while (!req_ready) begin
         waits++;
         @(negedge clk);
      end
      check(waits == n1 - 1, "R9", "clocks before next accept", 32'(waits), 32'(n1 - 1));
      @(posedge clk);
      body(op2, wd2, "R9");
      repeat (3) @(negedge clk);
   endtask

   // scoreboard monitor for read responses (R8)
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected rsp_valid", 32'(rsp_rdata), 32'h0);
         end else begin
            logic [DW-1:0] ev;
            ev = exp_q.pop_front();
            check(rsp_rdata == ev, "R8", "read data", 32'(rsp_rdata), 32'(ev));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL R9 watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [5:0] idle_a, idle_e;
      // reference timing: all fields distinct (R1, R2)
      cfg_edges = mk_edges(1, 9, 2, 6, 3, 7);
      cfg_cycle = mk_cycle(11, 12, 5);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_a = {bus_cs, bus_we, bus_re, bus_dc, bus_oe, req_ready};
      check(idle_a == 6'b111101 && !rsp_valid, "R9", "reset state", 32'(idle_a), 32'h3D);

      issue(2'd1, 16'h1234, "R1");
      issue(2'd0, 16'h00C3, "R7");
      issue(2'd3, 16'h5A5A, "R7");
      issue(2'd2, '0, "R8");

      // select-off beyond the write cycle stretches the cycle (R4)
      cfg_edges = mk_edges(0, 40, 0, 1, 0, 1);
      cfg_cycle = mk_cycle(3, 2, 1);
      issue(2'd1, 16'hBEEF, "R4");

      // every ordering violated (R3)
      cfg_edges = mk_edges(5, 2, 7, 3, 9, 1);
      cfg_cycle = mk_cycle(0, 0, 0);
      issue(2'd1, 16'h0F0F, "R3");
      issue(2'd2, '0, "R3");

      // access tick beyond every other value sets the read length (R4)
      cfg_edges = mk_edges(0, 4, 1, 3, 1, 3);
      cfg_cycle = mk_cycle(5, 5, 20);
      issue(2'd2, '0, "R4");

      // slow tick (R5)
      cfg_edges = mk_edges(1, 9, 2, 6, 3, 7);
      cfg_cycle = mk_cycle(11, 12, 5);
      cfg_slow  = 1'b1;
      issue(2'd1, 16'h7E81, "R5");
      issue(2'd2, '0, "R5");
      back_to_back(2'd1, 16'h1111, 2'd0, 16'h2222);
      cfg_slow  = 1'b0;

      // inverted polarity on every line (R6)
      cfg_pol = 4'hF;
      @(negedge clk);
      idle_a = {bus_cs, bus_we, bus_re, bus_dc, bus_oe, req_ready};
      check(idle_a == 6'b000001, "R6", "idle levels inverted", 32'(idle_a), 32'h01);
      issue(2'd0, 16'hC0DE, "R6");
      issue(2'd2, '0, "R6");
      cfg_pol = 4'h0;

      // back-to-back, including one-tick cycles (R9)
      back_to_back(2'd1, 16'hAAAA, 2'd1, 16'h5555);
      cfg_edges = mk_edges(0, 0, 0, 0, 0, 0);
      cfg_cycle = mk_cycle(0, 0, 0);
      back_to_back(2'd0, 16'h0001, 2'd1, 16'h0002);
      back_to_back(2'd1, 16'h0003, 2'd2, '0);

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R8", "responses outstanding", 32'(exp_q.size()), 32'h0);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule